// File: doc/BRIEF.md
# Chained Watchdog Down-Counter Bank

This block holds four 64-bit down-counters behind a single 32-bit register port. They share one clock. Each counter has a control word, a 64-bit reload value and a per-counter prescaler. A counter can run in one of two modes:

- **Single-shot:** the counter stops when it reaches zero.
- **Retrigger:** the counter reloads and restarts whenever the counter one index below it reaches its end count.

A watchdog is built from two counters. A retrigger counter does the supervising. Next to it sits a single-shot counter loaded with zero. Software pings the watchdog by disabling and then enabling the single-shot counter. That counter fires its end count at once, which reloads the watchdog in hardware. The watchdog is never stopped while this happens.

A select mask chooses which counters can raise the watchdog output. When a selected retrigger counter runs down to zero, the output is set and stays set until reset. The 64-bit remaining count is read as two words. Reading the low word captures the high word, so the two halves always come from the same instant.

Top module: `wdt_counter_bank`

## Requirements
- R1: After reset every control word, remaining count, reload value and the select mask read as zero, and `wdog_expired` is low.
- R2: Counter n's control word is at byte address n*16. Its fields read back as written:
  - bit 0: enable
  - bit 1: running flag (read only)
  - bits [3:2]: mode
  - bits [7:4]: trigger source
  - bits [15:8]: prescale
  - All other bits read as zero.
- R3: A write that takes enable from 0 to 1 loads the reload value, sets the running flag and clears the prescale phase. After that, the count falls by one every D clock edges. D is the prescale value, except that prescale values 0 and 1 give D = 1.
- R4: The end-count event is the cycle in which a running counter holds zero. In single-shot mode (mode 0b00; codes 0b01 and 0b10 behave the same), the running flag clears on the next edge and the count stays at zero until enable rises again. A reload of zero gives the end count in the cycle right after enabling.
- R5: A control write with enable 0 clears the running flag and freezes the count at its value before that edge.
- R6: A counter that is enabled, in mode 0b11 and has trigger source 0x5 reloads its initial value and restarts on the edge after counter n-1's end-count cycle.
- R7: Counter 0 has no lower neighbour, so trigger source 0x5 never restarts it.
- R8: Words at n*16+4 and n*16+8 set the low and high halves of the reload value.
  - Reading n*16+4 returns the low half of the live count and captures the live high half.
  - Reading n*16+8 returns that captured half.
- R9: The select mask is at byte address 0x40, one bit per counter in bits [3:0].
  - `wdog_expired` rises one edge after the end count of a selected counter in mode 0b11, and stays high until reset.
  - Unselected counters never raise it.
- R10: Read data appears on the cycle after `rd_en`. In a cycle after one without `rd_en`, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wdog_expired | output | 1 | Sticky watchdog expiry |

## Verification
A wrong reload, prescale phase or running flag shows up in the remaining count or the control word one edge after the fault. The bench therefore compares those words, after a chosen number of edges, against a closed-form model of the count.

A broken chain shows up as a watchdog count that is not back at its reload value one edge after the ping. A wrong select or sticky path shows up directly on `wdog_expired`.

A high-word capture error can only be seen when the high half changes between the two reads. The bench therefore reads the two halves across a borrow out of the low word.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 2 * DATA_W;
    localparam int PRESC_W = 8;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_LO   = 4'h4;
    localparam logic [3:0] OFF_HI   = 4'h8;

    localparam logic [3:0] SRC_PREV_END = 4'h5;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_RSV_A  = 2'b01,
        MODE_RSV_B  = 2'b10,
        MODE_RETRIG = 2'b11
    } mode_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [3:0]         src;
        mode_e              mode;
        logic               en;
    } ctrl_t;

    function automatic logic [PRESC_W-1:0] presc_div(input logic [PRESC_W-1:0] p);
        return (p < PRESC_W'(2)) ? PRESC_W'(1) : p;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.presc = w[15:8];
        c.src   = w[7:4];
        c.mode  = mode_e'(w[3:2]);
        c.en    = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic run);
        return {16'h0, c.presc, c.src, c.mode, run, c.en};
    endfunction
endpackage

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig_in,
    output ctrl_t             cfg_o,
    output logic              active_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ec_o
);
    ctrl_t              cfg_q;
    logic [CNT_W-1:0]   reload_q;
    logic [CNT_W-1:0]   count_q;
    logic               active_q;
    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] div;
    ctrl_t              cfg_new;

    assign div     = presc_div(cfg_q.presc);
    assign cfg_new = ctrl_from_word(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            reload_q <= '0;
            count_q  <= '0;
            active_q <= 1'b0;
            phase_q  <= '0;
        end else begin
            if (lo_we) reload_q[DATA_W-1:0]     <= wdata;
            if (hi_we) reload_q[CNT_W-1:DATA_W] <= wdata;
            if (ctrl_we) cfg_q <= cfg_new;

            if (ctrl_we && !cfg_new.en) begin
                active_q <= 1'b0;
            end else if (ctrl_we && cfg_new.en && !cfg_q.en) begin
                count_q  <= reload_q;
                active_q <= 1'b1;
                phase_q  <= '0;
            end else if (trig_in && cfg_q.en && cfg_q.mode == MODE_RETRIG) begin
                count_q  <= reload_q;
                active_q <= 1'b1;
                phase_q  <= '0;
            end else if (active_q) begin
                if (count_q == '0) begin
                    active_q <= 1'b0;
                end else if (phase_q >= div - PRESC_W'(1)) begin
                    count_q <= count_q - CNT_W'(1);
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + PRESC_W'(1);
                end
            end
        end
    end

    assign cfg_o    = cfg_q;
    assign active_o = active_q;
    assign count_o  = count_q;
    assign ec_o     = active_q && (count_q == '0);
endmodule

// File: rtl/wdt_bank_regif.sv
module wdt_bank_regif
    import wdt_bank_pkg::*;
#(
    parameter int NUM    = 4,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM-1:0]             sel_wdata,
    input  ctrl_t [NUM-1:0]            cfgs,
    input  logic [NUM-1:0]             active,
    input  logic [NUM-1:0][CNT_W-1:0]  counts,
    output logic [NUM-1:0]             ctrl_we,
    output logic [NUM-1:0]             lo_we,
    output logic [NUM-1:0]             hi_we,
    output logic [NUM-1:0]             sel_q,
    output logic [DATA_W-1:0]          rdata
);
    localparam int IDX_W    = (NUM > 1) ? $clog2(NUM) : 1;
    localparam int SEL_ADDR = NUM * 16;

    logic             in_bank;
    logic             at_sel;
    logic [IDX_W-1:0] idx;
    logic [3:0]       off;
    logic [NUM-1:0][DATA_W-1:0] hi_lat;

    assign in_bank = (int'(addr) < SEL_ADDR);
    assign at_sel  = (int'(addr) == SEL_ADDR);
    assign idx     = addr[IDX_W+3:4];
    assign off     = addr[3:0];

    always_comb begin
        ctrl_we = '0;
        lo_we   = '0;
        hi_we   = '0;
        if (wr_en && in_bank) begin
            case (off)
                OFF_CTRL: ctrl_we[idx] = 1'b1;
                OFF_LO:   lo_we[idx]   = 1'b1;
                OFF_HI:   hi_we[idx]   = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            hi_lat <= '0;
            rdata  <= '0;
        end else begin
            if (wr_en && at_sel) sel_q <= sel_wdata;
            rdata <= '0;
            if (rd_en && in_bank) begin
                case (off)
                    OFF_CTRL: rdata <= ctrl_to_word(cfgs[idx], active[idx]);
                    OFF_LO: begin
                        rdata       <= counts[idx][DATA_W-1:0];
                        hi_lat[idx] <= counts[idx][CNT_W-1:DATA_W];
                    end
                    OFF_HI:   rdata <= hi_lat[idx];
                    default:  ;
                endcase
            end else if (rd_en && at_sel) begin
                rdata <= DATA_W'(sel_q);
            end
        end
    end
endmodule

// File: rtl/wdt_expiry_flag.sv
module wdt_expiry_flag #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] ec,
    input  logic [NUM-1:0] sel,
    input  logic [NUM-1:0] retrig,
    output logic           expired
);
    always_ff @(posedge clk) begin
        if (rst)                      expired <= 1'b0;
        else if (|(ec & sel & retrig)) expired <= 1'b1;
    end
endmodule

// File: rtl/wdt_counter_bank.sv
module wdt_counter_bank
    import wdt_bank_pkg::*;
#(
    parameter int NUM    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              wdog_expired
);
    ctrl_t [NUM-1:0]            cfgs;
    logic  [NUM-1:0]            cnt_active;
    logic  [NUM-1:0]            cnt_en;
    logic  [NUM-1:0][CNT_W-1:0] counts;
    logic  [NUM-1:0]            ec;
    logic  [NUM-1:0]            trig;
    logic  [NUM-1:0]            retrig_mode;
    logic  [NUM-1:0]            ctrl_we, lo_we, hi_we;
    logic  [NUM-1:0]            sel_q;

    wdt_bank_regif #(.NUM(NUM), .ADDR_W(ADDR_W)) i_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .sel_wdata(wdata[NUM-1:0]), .cfgs(cfgs), .active(cnt_active),
        .counts(counts), .ctrl_we(ctrl_we), .lo_we(lo_we), .hi_we(hi_we),
        .sel_q(sel_q), .rdata(rdata)
    );

    for (genvar i = 0; i < NUM; i++) begin : g_cnt
        if (i == 0) begin : g_first
            assign trig[i] = 1'b0;
        end else begin : g_chain
            assign trig[i] = (cfgs[i].src == SRC_PREV_END) && ec[i-1];
        end
        assign retrig_mode[i] = (cfgs[i].mode == MODE_RETRIG);
        assign cnt_en[i]      = cfgs[i].en;

        wdt_down_counter i_cnt (
            .clk(clk), .rst(rst), .ctrl_we(ctrl_we[i]), .lo_we(lo_we[i]),
            .hi_we(hi_we[i]), .wdata(wdata), .trig_in(trig[i]),
            .cfg_o(cfgs[i]), .active_o(cnt_active[i]), .count_o(counts[i]),
            .ec_o(ec[i])
        );
    end

    wdt_expiry_flag #(.NUM(NUM)) i_expiry (
        .clk(clk), .rst(rst), .ec(ec), .sel(sel_q), .retrig(retrig_mode),
        .expired(wdog_expired)
    );
endmodule

// File: rtl/wdt_bank_checker.sv
module wdt_bank_checker #(
    parameter int NUM = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_en,
    input logic [31:0]    rdata,
    input logic           wdog_expired,
    input logic [NUM-1:0] sel_q,
    input logic [NUM-1:0] cnt_en,
    input logic [NUM-1:0] cnt_active,
    input logic [NUM-1:0] ec,
    input logic [NUM-1:0] retrig_mode
);
    assert_expiry_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        wdog_expired |=> wdog_expired);

    assert_expiry_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_expired) |-> $past(|(ec & sel_q & retrig_mode)));

    assert_first_not_retriggered_R7: assert property (@(posedge clk) disable iff (rst)
        ec[0] |=> !cnt_active[0]);

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == 32'h0);

    for (genvar i = 0; i < NUM; i++) begin : g_run
        assert_run_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
            cnt_active[i] |-> cnt_en[i]);
    end
endmodule

bind wdt_counter_bank wdt_bank_checker #(.NUM(NUM)) i_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rdata(rdata),
    .wdog_expired(wdog_expired), .sel_q(sel_q), .cnt_en(cnt_en),
    .cnt_active(cnt_active), .ec(ec), .retrig_mode(retrig_mode)
);

// File: tb/test_wdt_counter_bank.sv
module test_wdt_counter_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        wdog_expired;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wdt_counter_bank i_wdt_counter_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wdog_expired(wdog_expired)
    );

    function automatic logic [7:0] a_ctl(input int n); return 8'(n * 16);     endfunction
    function automatic logic [7:0] a_lo(input int n);  return 8'(n * 16 + 4); endfunction
    function automatic logic [7:0] a_hi(input int n);  return 8'(n * 16 + 8); endfunction
    localparam logic [7:0] A_SEL = 8'h40;

    function automatic longint unsigned div_of(input int p);
        return (p < 2) ? 1 : longint'(p);
    endfunction
    function automatic longint unsigned exp_count(input longint unsigned r, input int p,
                                                  input longint unsigned n);
        longint unsigned steps = n / div_of(p);
        return (steps >= r) ? 0 : r - steps;
    endfunction
    function automatic bit exp_run(input longint unsigned r, input int p,
                                   input longint unsigned n);
        return n <= r * div_of(p);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'h5EED);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(a_ctl(0), d); check("R1 ctrl0", 64'(d), 64'h0);
        rd(a_lo(1), d);  check("R1 count1", 64'(d), 64'h0);
        rd(a_hi(2), d);  check("R1 high2", 64'(d), 64'h0);
        rd(A_SEL, d);    check("R1 select", 64'(d), 64'h0);
        check("R1 expired", 64'(wdog_expired), 64'h0);

        // R2 control field readback, R10 idle read data
        wr(a_ctl(2), 32'hFFFF_0734);
        rd(a_ctl(2), d); check("R2 ctrl2 readback", 64'(d), 64'h0734);
        idle(1);
        check("R10 rdata idle", 64'(rdata), 64'h0);

        // R3/R4 random single-shot runs on counter 2
        for (int it = 0; it < 24; it++) begin
            longint unsigned r = longint'($urandom_range(0, 40));
            int p  = int'($urandom_range(0, 4));
            int n  = int'($urandom_range(0, 100));
            if (it == 0) begin r = 0; p = 0; n = 0; end
            if (it == 1) begin r = 0; p = 3; n = 1; end
            wr(a_ctl(2), 32'h0);
            wr(a_lo(2), 32'(r));
            wr(a_hi(2), 32'h0);
            wr(a_ctl(2), (32'(p) << 8) | 32'h1);
            idle(n);
            rd(a_lo(2), d);
            check("R3 count", 64'(d), 64'(exp_count(r, p, longint'(n))));
            rd(a_ctl(2), d);
            check("R4 run flag", 64'(d),
                  64'((32'(p) << 8) | (32'(exp_run(r, p, longint'(n + 1))) << 1) | 32'h1));
        end

        // R5 disable freezes the count
        wr(a_lo(2), 32'd100);
        wr(a_ctl(2), 32'h0);
        wr(a_ctl(2), 32'h1);
        idle(5);
        wr(a_ctl(2), 32'h0);
        idle(3);
        rd(a_lo(2), d);  check("R5 frozen count", 64'(d), 64'd95);
        rd(a_ctl(2), d); check("R5 stopped", 64'(d), 64'h0);

        // R8 high word captured by the low read
        wr(a_lo(3), 32'd3);
        wr(a_hi(3), 32'd1);
        wr(a_ctl(3), 32'h1);
        rd(a_lo(3), d); check("R8 low first", 64'(d), 64'd3);
        idle(10);
        rd(a_hi(3), d); check("R8 captured high", 64'(d), 64'd1);
        rd(a_lo(3), d); check("R8 low later", 64'(d), 64'hFFFF_FFF7);
        rd(a_hi(3), d); check("R8 high later", 64'(d), 64'd0);
        wr(a_ctl(3), 32'h0);

        // R6 chained retrigger, counter 1 watched through counter 0
        wr(a_lo(0), 32'h0);
        wr(a_hi(0), 32'h0);
        wr(a_ctl(0), 32'h0);
        wr(a_lo(1), 32'd20);
        wr(a_ctl(1), 32'h025D);
        idle(9);
        wr(a_ctl(0), 32'h0);
        wr(a_ctl(0), 32'h1);
        idle(1);
        rd(a_lo(1), d); check("R6 reloaded by ping", 64'(d), 64'd20);
        rd(a_ctl(0), d); check("R4 zero reload stops", 64'(d), 64'h1);
        idle(60);
        check("R9 unselected no expiry", 64'(wdog_expired), 64'h0);

        // R9 selected expiry is sticky
        wr(A_SEL, 32'h2);
        rd(A_SEL, d); check("R9 select readback", 64'(d), 64'h2);
        wr(a_ctl(0), 32'h0);
        wr(a_ctl(0), 32'h1);
        idle(1);
        rd(a_lo(1), d); check("R6 restart after stop", 64'(d), 64'd20);
        check("R9 no expiry yet", 64'(wdog_expired), 64'h0);
        idle(50);
        check("R9 expired", 64'(wdog_expired), 64'h1);
        wr(a_ctl(0), 32'h0);
        wr(a_ctl(0), 32'h1);
        idle(3);
        check("R9 sticky", 64'(wdog_expired), 64'h1);

        // R7 counter 0 ignores trigger source 0x5
        wr(a_ctl(0), 32'h0);
        wr(a_lo(0), 32'd5);
        wr(a_ctl(0), 32'h005D);
        idle(10);
        wr(a_lo(3), 32'h0);
        wr(a_hi(3), 32'h0);
        wr(a_ctl(3), 32'h0);
        wr(a_ctl(3), 32'h1);
        idle(3);
        rd(a_ctl(0), d); check("R7 counter0 idle", 64'(d), 64'h005D);
        rd(a_lo(0), d);  check("R7 counter0 count", 64'(d), 64'h0);

        finish_run();
    end
endmodule